// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps two pending-interrupt vectors with one bit per processor: one for inter-processor interrupts and one for interval-timer interrupts. Each pending bit drives an interrupt level output to its processor. Software changes the vectors through a small register file. A combined control register can post inter-processor interrupts, clear them and acknowledge timer interrupts in a single write. Three single-purpose registers each take a plain processor bitmask.

A periodic tick from outside the block marks a timer interrupt pending for every processor. Redundant posts and clears of idle bits leave the state unchanged. Each raises a one-cycle indication instead. A control write that carries no recognised request sets a sticky flag. Reads are combinational on the register select. A read of the control register also returns the identifier of the processor that is reading.

Top module: `ictl_top`

## Requirements
- R1: After reset both pending vectors, all interrupt outputs and all three flags are zero.
- R2: A write to the control register (select 0) sets the inter-processor pending bit of each processor whose bit in data bits 15:12 is 1 (bit 12 is processor 0). The output is visible after the clock edge that takes the write.
- R3: In a control-register write, data bits 11:8 clear the inter-processor pending bit of each processor selected (bit 8 is processor 0).
- R4: In a control-register write, data bits 7:4 clear the timer pending bit of each processor selected (bit 4 is processor 0).
- R5: A control-register write with only bit 28 set (the non-existent-memory acknowledge) changes no pending bit and does not set the unsupported flag.
- R6: A post to a processor whose inter-processor bit is already pending changes nothing. It raises `post_dup` for exactly one cycle.
- R7: A clear to a processor whose inter-processor bit is not pending changes nothing. It raises `clr_stray` for exactly one cycle.
- R8: A cycle with `tick` high sets the timer pending bit of every processor. Inter-processor bits are unaffected.
- R9: When a tick and a software timer clear hit the same processor in one cycle, that processor's timer bit ends up 0.
- R10: When one write both posts and clears the inter-processor bit of the same processor, the clear wins and the bit ends up 0.
- R11: Select 1 reads the inter-processor pending vector in bits 3:0, and a write to it clears the bits set in the data. Select 2 does the same for the timer vector. A write to select 3 posts inter-processor interrupts to the bits set in the data. A read of select 3 returns 0.
- R12: A read of select 0 returns inter-processor pending bits in 11:8, timer pending bits in 7:4 and `cpu_id` in 1:0. All other bits are zero.
- R13: A control-register write whose bits 15:4 and bit 28 are all zero sets `wr_unsup`. The flag stays set until reset.
- R14: Selects 4 to 7 read as zero, and writes to them change no state or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for reads and writes |
| wdata | input | 32 | Write data |
| cpu_id | input | 2 | Identifier of the accessing processor |
| tick | input | 1 | Periodic timer tick |
| rdata | output | 32 | Combinational read data for `reg_sel` |
| ipi_irq | output | 4 | Inter-processor interrupt level per processor |
| tmr_irq | output | 4 | Timer interrupt level per processor |
| post_dup | output | 1 | One-cycle pulse: redundant inter-processor post |
| clr_stray | output | 1 | One-cycle pulse: clear of a non-pending bit |
| wr_unsup | output | 1 | Sticky: control write with no recognised request |

## Verification
A corrupted pending bit appears at once on its interrupt level output. It also appears in both read views of the vector in the same cycle, so every directed step compares the outputs with the read-back data. A wrong field decode shows up one edge after the write: either the wrong processor's level changes or one of the flags pulses. Wrong priority between tick and clear only shows when both arrive in one cycle, so that case is driven on purpose. A stuck or dropped sticky flag shows after the next unrelated write.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL     = 3'd0,
    SEL_IPI_PEND = 3'd1,
    SEL_TMR_PEND = 3'd2,
    SEL_IPI_POST = 3'd3
  } reg_sel_e;

  localparam int unsigned POST_LSB = 12;
  localparam int unsigned ICLR_LSB = 8;
  localparam int unsigned TCLR_LSB = 4;
  localparam int unsigned NXM_BIT  = 28;

  // Build the control-register read word.
  function automatic logic [DATA_W-1:0] ctrl_word(input logic [3:0] ipi,
                                                  input logic [3:0] tmr,
                                                  input logic [1:0] id);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ICLR_LSB +: 4] = ipi;
    w[TCLR_LSB +: 4] = tmr;
    w[1:0] = id;
    return w;
  endfunction

  // Next state of a pending bank; clear takes priority over set.
  function automatic logic [3:0] pend_next(input logic [3:0] cur,
                                           input logic [3:0] set,
                                           input logic [3:0] clr);
    return (cur | set) & ~clr;
  endfunction

endpackage

// File: rtl/ictl_wr_decode.sv
module ictl_wr_decode
  import ictl_pkg::*;
#(
  parameter int unsigned NCPU = 4
) (
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCPU-1:0]   ipi_set,
  output logic [NCPU-1:0]   ipi_clr,
  output logic [NCPU-1:0]   tmr_clr,
  output logic              unsup
);

  logic is_ctrl, is_ipend, is_tpend, is_ipost;

  always_comb begin
    is_ctrl  = wr_en && (reg_sel == SEL_CTRL);
    is_ipend = wr_en && (reg_sel == SEL_IPI_PEND);
    is_tpend = wr_en && (reg_sel == SEL_TMR_PEND);
    is_ipost = wr_en && (reg_sel == SEL_IPI_POST);

    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    if (is_ctrl) begin
      ipi_set = wdata[POST_LSB +: NCPU];
      ipi_clr = wdata[ICLR_LSB +: NCPU];
      tmr_clr = wdata[TCLR_LSB +: NCPU];
    end
    if (is_ipost) ipi_set = wdata[NCPU-1:0];
    if (is_ipend) ipi_clr = wdata[NCPU-1:0];
    if (is_tpend) tmr_clr = wdata[NCPU-1:0];

    unsup = is_ctrl && (wdata[15:4] == 12'd0) && !wdata[NXM_BIT];
  end

endmodule

// File: rtl/ictl_pend_bank.sv
module ictl_pend_bank #(
  parameter int unsigned NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] set,
  input  logic [NCPU-1:0] clr,
  output logic [NCPU-1:0] pend,
  output logic [NCPU-1:0] dup,
  output logic [NCPU-1:0] stray
);

  for (genvar g = 0; g < NCPU; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        pend[g] <= 1'b0;
      else if (clr[g])   pend[g] <= 1'b0;
      else if (set[g])   pend[g] <= 1'b1;
    end
    assign dup[g]   = set[g] & pend[g];
    assign stray[g] = clr[g] & ~pend[g];
  end

endmodule

// File: rtl/ictl_top.sv
module ictl_top
  import ictl_pkg::*;
#(
  parameter int unsigned NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       wdata,
  input  logic [1:0]        cpu_id,
  input  logic              tick,
  output logic [31:0]       rdata,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq,
  output logic              post_dup,
  output logic              clr_stray,
  output logic              wr_unsup
);

  logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr, tmr_set;
  logic [NCPU-1:0] ipi_dup, ipi_stray, tmr_dup_unused, tmr_stray_unused;
  logic            unsup_ev;

  ictl_wr_decode #(.NCPU(NCPU)) u_dec (
    .wr_en   (wr_en),
    .reg_sel (reg_sel),
    .wdata   (wdata),
    .ipi_set (ipi_set),
    .ipi_clr (ipi_clr),
    .tmr_clr (tmr_clr),
    .unsup   (unsup_ev)
  );

  assign tmr_set = {NCPU{tick}};

  ictl_pend_bank #(.NCPU(NCPU)) u_ipi (
    .clk (clk), .rst_n (rst_n),
    .set (ipi_set), .clr (ipi_clr),
    .pend (ipi_irq), .dup (ipi_dup), .stray (ipi_stray)
  );

  ictl_pend_bank #(.NCPU(NCPU)) u_tmr (
    .clk (clk), .rst_n (rst_n),
    .set (tmr_set), .clr (tmr_clr),
    .pend (tmr_irq), .dup (tmr_dup_unused), .stray (tmr_stray_unused)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_dup  <= 1'b0;
      clr_stray <= 1'b0;
      wr_unsup  <= 1'b0;
    end else begin
      post_dup  <= |ipi_dup;
      clr_stray <= |ipi_stray;
      if (unsup_ev) wr_unsup <= 1'b1;
    end
  end

  logic [3:0] ipi4, tmr4;
  always_comb begin
    ipi4 = '0;
    tmr4 = '0;
    ipi4[NCPU-1:0] = ipi_irq;
    tmr4[NCPU-1:0] = tmr_irq;
    case (reg_sel)
      SEL_CTRL:     rdata = ctrl_word(ipi4, tmr4, cpu_id);
      SEL_IPI_PEND: rdata = {28'd0, ipi4};
      SEL_TMR_PEND: rdata = {28'd0, tmr4};
      default:      rdata = '0;
    endcase
  end

endmodule

// File: rtl/ictl_checker.sv
module ictl_checker #(
  parameter int unsigned NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [NCPU-1:0] ipi_set,
  input logic [NCPU-1:0] ipi_clr,
  input logic [NCPU-1:0] tmr_clr,
  input logic [NCPU-1:0] ipi_irq,
  input logic [NCPU-1:0] tmr_irq,
  input logic            wr_unsup
);

  assert_tick_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((tmr_irq | $past(tmr_clr)) == {NCPU{1'b1}}));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_clr) |=> ((tmr_irq & $past(tmr_clr)) == '0));

  assert_ipi_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ipi_clr) |=> ((ipi_irq & $past(ipi_clr)) == '0));

  assert_ipi_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ipi_set & ~ipi_clr)) |=>
      ((ipi_irq & $past(ipi_set & ~ipi_clr)) == $past(ipi_set & ~ipi_clr)));

  assert_ipi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_set == '0 && ipi_clr == '0) |=> $stable(ipi_irq));

  assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unsup |=> wr_unsup);

endmodule

bind ictl_top ictl_checker #(.NCPU(NCPU)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .ipi_set  (ipi_set),
  .ipi_clr  (ipi_clr),
  .tmr_clr  (tmr_clr),
  .ipi_irq  (ipi_irq),
  .tmr_irq  (tmr_irq),
  .wr_unsup (wr_unsup)
);

// File: tb/tb_ictl_top.sv
module tb_ictl_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  reg_sel;
  logic [31:0] wdata;
  logic [1:0]  cpu_id;
  logic        tick;
  logic [31:0] rdata;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        post_dup, clr_stray, wr_unsup;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ictl_top dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .reg_sel (reg_sel),
    .wdata (wdata), .cpu_id (cpu_id), .tick (tick), .rdata (rdata),
    .ipi_irq (ipi_irq), .tmr_irq (tmr_irq), .post_dup (post_dup),
    .clr_stray (clr_stray), .wr_unsup (wr_unsup)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One write cycle; state and flags are sampled at the following negedge.
  task automatic wr(input logic [2:0] s, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wdata = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; reg_sel = 3'd0; wdata = '0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    reg_sel = s;
    #1 d = rdata;
    reg_sel = 3'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; reg_sel = '0; wdata = '0; cpu_id = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ipi", {28'd0, ipi_irq}, 32'h0);
    check("R1 tmr", {28'd0, tmr_irq}, 32'h0);
    check("R1 flags", {29'd0, post_dup, clr_stray, wr_unsup}, 32'h0);
  endtask

  task automatic t_post_clear();
    logic [31:0] d;
    do_reset();
    wr(3'd0, 32'h0000_5000);
    check("R2 post 0,2", {28'd0, ipi_irq}, 32'h5);
    wr(3'd0, 32'h0000_0100);
    check("R3 clear 0", {28'd0, ipi_irq}, 32'h4);
    check("R3 no stray", {31'd0, clr_stray}, 32'h0);
    rd(3'd1, d);
    check("R11 ipi read", d, 32'h4);
  endtask

  task automatic t_dup_stray();
    do_reset();
    wr(3'd0, 32'h0000_2000);
    check("R6 no dup first", {31'd0, post_dup}, 32'h0);
    wr(3'd0, 32'h0000_2000);
    check("R6 dup pulse", {31'd0, post_dup}, 32'h1);
    check("R6 unchanged", {28'd0, ipi_irq}, 32'h2);
    @(negedge clk);
    check("R6 one cycle", {31'd0, post_dup}, 32'h0);
    wr(3'd0, 32'h0000_0800);
    check("R7 stray pulse", {31'd0, clr_stray}, 32'h1);
    check("R7 unchanged", {28'd0, ipi_irq}, 32'h2);
    @(negedge clk);
    check("R7 one cycle", {31'd0, clr_stray}, 32'h0);
  endtask

  task automatic t_tick();
    logic [31:0] d;
    do_reset();
    wr(3'd3, 32'h1);
    pulse_tick();
    check("R8 all tmr", {28'd0, tmr_irq}, 32'hF);
    check("R8 ipi kept", {28'd0, ipi_irq}, 32'h1);
    wr(3'd0, 32'h0000_0060);
    check("R4 tmr clear 1,2", {28'd0, tmr_irq}, 32'h9);
    wr(3'd2, 32'h1);
    check("R11 tmr reg clear", {28'd0, tmr_irq}, 32'h8);
    rd(3'd2, d);
    check("R11 tmr read", d, 32'h8);
    wr(3'd0, 32'h0000_0030, 1'b1);
    check("R9 clear beats tick", {28'd0, tmr_irq}, 32'hC);
  endtask

  task automatic t_combined();
    logic [31:0] d;
    do_reset();
    wr(3'd3, 32'h3);
    pulse_tick();
    wr(3'd0, 32'h0000_C1F0);
    check("R2/R3 combined ipi", {28'd0, ipi_irq}, 32'hE);
    check("R4 combined tmr", {28'd0, tmr_irq}, 32'h0);
    wr(3'd0, 32'h0000_2200);
    check("R10 clear beats post", {28'd0, ipi_irq}, 32'hC);
    wr(3'd1, 32'h4);
    check("R11 ipi reg clear", {28'd0, ipi_irq}, 32'h8);
    rd(3'd3, d);
    check("R11 post reg reads 0", d, 32'h0);
    pulse_tick();
    cpu_id = 2'd3;
    rd(3'd0, d);
    check("R12 ctrl read", d, 32'h0000_08F3);
    cpu_id = 2'd2;
    rd(3'd0, d);
    check("R12 ctrl id", d, 32'h0000_08F2);
  endtask

  task automatic t_unsup();
    logic [31:0] d;
    do_reset();
    wr(3'd3, 32'h2);
    wr(3'd0, 32'h1000_0000);
    check("R5 nxm no flag", {31'd0, wr_unsup}, 32'h0);
    check("R5 nxm no change", {24'd0, ipi_irq, tmr_irq}, 32'h20);
    for (int s = 4; s < 8; s++) begin
      wr(s[2:0], 32'hFFFF_FFFF);
      rd(s[2:0], d);
      check("R14 unmapped read", d, 32'h0);
    end
    check("R14 no state", {24'd0, ipi_irq, tmr_irq}, 32'h20);
    check("R14 no flag", {29'd0, post_dup, clr_stray, wr_unsup}, 32'h0);
    wr(3'd0, 32'h0000_000F);
    check("R13 unsup set", {31'd0, wr_unsup}, 32'h1);
    wr(3'd0, 32'h0000_1000);
    repeat (3) @(negedge clk);
    check("R13 sticky", {31'd0, wr_unsup}, 32'h1);
    check("R13 post still ok", {28'd0, ipi_irq}, 32'h3);
    do_reset();
    check("R1 unsup cleared", {31'd0, wr_unsup}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_post_clear();
    t_dup_stray();
    t_tick();
    t_combined();
    t_unsup();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule